// File: doc/BRIEF.md
# Dual-Clock FIFO with Master/Partial Reset and Rewind

This block is an 18-bit-wide first-in first-out buffer. Its producer and its consumer run on unrelated clocks. A producer pushes words on its own clock, and a consumer pops them on a second clock into a held output register. The output register drives the data pins only while output enable is high. The storage depth is a power of two set by a parameter. Each side keeps a binary pointer one bit wider than the address. The pointers cross to the other side as Gray code through two-flop synchronisers. Empty and almost-empty are computed on the consumer side. Full, half-full and almost-full are computed on the producer side.

Two reset levels exist. Master reset clears both pointers and the output register. It also captures the two flag thresholds from their input pins. Partial reset clears the same pointers and output register but leaves the captured thresholds alone, so a running system can flush the buffer without reloading them. A rewind input, active low, returns the read pointer to the first memory location so that stored data can be read a second time. Reads follow standard timing: a word reaches the output only through an explicit read.

Top module: `dualclk_fifo`

## Requirements
- R1: A word written into an empty buffer does not appear on `q` until a read is taken (`rd_en` high on a rising `rclk` edge while not empty). Between reads, `q` holds the last word read.
- R2: Words leave in the order they were written, with no loss or corruption, including after the pointers wrap around the storage more than once.
- R3: `empty` is high exactly when the buffer holds no word. A read request while empty leaves `q` and the read position unchanged.
- R4: `full` is high exactly when the buffer holds DEPTH words. A write request while full is dropped and does not disturb the stored data.
- R5: `half_full` is high when the buffer holds more than DEPTH/2 words.
- R6: `almost_empty` is high when the buffer holds no more than the almost-empty threshold captured at the last master reset.
- R7: `almost_full` is high when the buffer holds at least DEPTH minus the almost-full threshold captured at the last master reset.
- R8: While `mrst_n` is low (synchronous, active low), both pointers and the output register clear and the thresholds are captured from `ae_level` and `af_level`. After release the buffer reads as empty with `q` equal to zero.
- R9: While `prst_n` is low (synchronous, active low), both pointers and the output register clear, and the previously captured thresholds are kept, whatever `ae_level` and `af_level` show.
- R10: `rt_n` low on a rising `rclk` edge sets the read pointer to memory location 0. It takes precedence over a read in the same cycle, which is then not taken, and it leaves `q` unchanged. It is meant for use while no more than DEPTH words have been written since the last reset.
- R11: `q` equals the output register while `oe` is high and is all zeros while `oe` is low. Toggling `oe` does not alter the register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| mrst_n | input | 1 | Master reset, active low, sampled on both clocks |
| prst_n | input | 1 | Partial reset, active low, sampled on both clocks |
| wr_en | input | 1 | Write request on rising `wclk` |
| din | input | DW (18) | Write data |
| rd_en | input | 1 | Read request on rising `rclk` |
| rt_n | input | 1 | Rewind read pointer to location 0, active low |
| oe | input | 1 | Output enable for `q` |
| ae_level | input | AW (4) | Almost-empty threshold, captured at master reset |
| af_level | input | AW (4) | Almost-full threshold, captured at master reset |
| q | output | DW (18) | Read data, zero while `oe` is low |
| empty | output | 1 | No words stored (read side) |
| almost_empty | output | 1 | Occupancy at or below the almost-empty threshold (read side) |
| full | output | 1 | DEPTH words stored (write side) |
| half_full | output | 1 | Occupancy above DEPTH/2 (write side) |
| almost_full | output | 1 | Occupancy at or above DEPTH minus the almost-full threshold (write side) |

## Verification
The bench walks occupancy through every value from 0 to DEPTH and back, comparing all five flags at each level. A flag compare that is off by one therefore shows up at a single level as a wrong flag. A design that accepts a write while full overwrites the oldest word, and a design that accepts a read while empty changes `q`; both are exposed when the buffer is drained. Streaming far past twice the depth catches a pointer that loses its wrap bit, which would read as empty or full at the wrong time. After a partial reset, the threshold pins are changed before the flags are checked, so a design that recaptures them moves the almost flags. Rewind is issued together with a read in the same cycle, so a design that lets the read through, or that moves `q` on rewind, returns the wrong data.

// File: rtl/dualclk_fifo_pkg.sv
// Shared definitions for the dual-clock FIFO.
// Assumes: nothing beyond IEEE 1800-2017 synthesizable subset.
package dualclk_fifo_pkg;

    // Number of flops in each clock-domain-crossing synchroniser.
    localparam int unsigned SYNC_STAGES = 2;

    // Read-side action taken on one rclk edge, in priority order.
    typedef enum logic [1:0] {
        RD_HOLD   = 2'd0,
        RD_POP    = 2'd1,
        RD_REWIND = 2'd2
    } rd_action_e;

endpackage

// File: rtl/fifo_gray_sync.sv
// Carries a Gray-coded pointer into another clock domain through a
// chain of flops, then converts it back to binary.
// Assumes: the source changes by at most one bit per source edge
// (except during rewind or reset, when the far side is expected to be idle).
module fifo_gray_sync #(
    parameter int unsigned W      = 5,
    parameter int unsigned STAGES = dualclk_fifo_pkg::SYNC_STAGES
) (
    input  logic         clk,
    input  logic         clr_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] stage_q [STAGES];

    // Build the flop chain, one flop per stage.
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            // First stage samples the foreign-domain Gray code.
            always_ff @(posedge clk) begin
                if (!clr_n) stage_q[s] <= '0;
                else        stage_q[s] <= gray_in;
            end
        end else begin : g_rest
            // Later stages resolve metastability.
            always_ff @(posedge clk) begin
                if (!clr_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    // Convert the synchronised Gray code back to binary.
    always_comb begin
        bin_out[W-1] = stage_q[STAGES-1][W-1];
        for (int i = int'(W) - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ stage_q[STAGES-1][i];
        end
    end

endmodule

// File: rtl/fifo_dp_ram.sv
// Storage array: one synchronous write port, one asynchronous read port.
// Assumes: a location is read only after its write has crossed the
// pointer synchroniser, so read and write never hit the same word at once.
module fifo_dp_ram #(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 18
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int unsigned DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    // Store a word on an accepted write.
    always_ff @(posedge wclk) begin
        if (we) mem[waddr] <= wdata;
    end

    assign rdata = mem[raddr];

endmodule

// File: rtl/fifo_wr_ctrl.sv
// Write side: pointer, full / half-full / almost-full flags and the
// almost-full threshold register.
// Assumes: mrst_n and prst_n are synchronous to wclk at this point, and
// rptr_sync is the read pointer already brought into the wclk domain.
module fifo_wr_ctrl #(
    parameter int unsigned AW = 4
) (
    input  logic          wclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] af_level,
    input  logic [AW:0]   rptr_sync,
    output logic [AW:0]   wptr,
    output logic [AW:0]   wgray,
    output logic          we,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);

    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_P  = PW'(DEPTH / 2);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wgray_q;
    logic [PW-1:0] wptr_nx;
    logic [PW-1:0] occ;
    logic [AW-1:0] af_lvl_q;
    logic          ptr_clr;

    assign ptr_clr = !mrst_n || !prst_n;
    assign occ     = wptr_q - rptr_sync;
    assign full    = (occ == DEPTH_P);
    assign we      = wr_en && !full;
    assign wptr_nx = wptr_q + PW'(1);

    assign half_full   = (occ > HALF_P);
    assign almost_full = (occ >= (DEPTH_P - PW'(af_lvl_q)));

    // Advance the write pointer and its Gray copy on each accepted write.
    always_ff @(posedge wclk) begin
        if (ptr_clr) begin
            wptr_q  <= '0;
            wgray_q <= '0;
        end else if (we) begin
            wptr_q  <= wptr_nx;
            wgray_q <= wptr_nx ^ (wptr_nx >> 1);
        end
    end

    // Capture the almost-full threshold only during master reset.
    always_ff @(posedge wclk) begin
        if (!mrst_n) af_lvl_q <= af_level;
    end

    assign wptr  = wptr_q;
    assign wgray = wgray_q;

    assert_no_overflow_R4: assert property (@(posedge wclk) disable iff (ptr_clr)
        occ <= DEPTH_P);

    assert_full_write_dropped_R4: assert property (@(posedge wclk) disable iff (ptr_clr)
        (full && wr_en) |=> $stable(wptr_q));

    assert_full_implies_upper_flags_R5: assert property (@(posedge wclk) disable iff (ptr_clr)
        full |-> (half_full && almost_full));

endmodule

// File: rtl/fifo_rd_ctrl.sv
// Read side: pointer with rewind, output register, empty and
// almost-empty flags, and the almost-empty threshold register.
// Assumes: mrst_n and prst_n are synchronous to rclk at this point, and
// wptr_sync is the write pointer already brought into the rclk domain.
module fifo_rd_ctrl
    import dualclk_fifo_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 18
) (
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          rd_en,
    input  logic          rt_n,
    input  logic [AW-1:0] ae_level,
    input  logic [AW:0]   wptr_sync,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rptr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          almost_empty
);

    localparam int unsigned PW    = AW + 1;
    localparam int unsigned DEPTH = 1 << AW;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] rptr_q;
    logic [PW-1:0] rgray_q;
    logic [PW-1:0] rptr_nx;
    logic [PW-1:0] occ;
    logic [DW-1:0] dout_q;
    logic [AW-1:0] ae_lvl_q;
    logic          ptr_clr;
    rd_action_e    act;

    assign ptr_clr      = !mrst_n || !prst_n;
    assign occ          = wptr_sync - rptr_q;
    assign empty        = (occ == '0);
    assign almost_empty = (occ <= PW'(ae_lvl_q));
    assign rptr_nx      = rptr_q + PW'(1);

    // Pick this edge's action; rewind outranks a read.
    always_comb begin
        if (!rt_n)                act = RD_REWIND;
        else if (rd_en && !empty) act = RD_POP;
        else                      act = RD_HOLD;
    end

    // Update the read pointer, its Gray copy and the output register.
    always_ff @(posedge rclk) begin
        if (ptr_clr) begin
            rptr_q  <= '0;
            rgray_q <= '0;
            dout_q  <= '0;
        end else begin
            case (act)
                RD_REWIND: begin
                    rptr_q  <= '0;
                    rgray_q <= '0;
                end
                RD_POP: begin
                    rptr_q  <= rptr_nx;
                    rgray_q <= rptr_nx ^ (rptr_nx >> 1);
                    dout_q  <= mem_rdata;
                end
                default: ;
            endcase
        end
    end

    // Capture the almost-empty threshold only during master reset.
    always_ff @(posedge rclk) begin
        if (!mrst_n) ae_lvl_q <= ae_level;
    end

    assign rptr  = rptr_q;
    assign rgray = rgray_q;
    assign dout  = dout_q;

    assert_empty_read_ignored_R3: assert property (@(posedge rclk) disable iff (ptr_clr)
        (empty && rd_en && rt_n) |=> ($stable(rptr_q) && $stable(dout_q)));

    assert_no_underflow_R3: assert property (@(posedge rclk) disable iff (ptr_clr)
        occ <= DEPTH_P);

    assert_rewind_to_first_R10: assert property (@(posedge rclk) disable iff (ptr_clr)
        !rt_n |=> (rptr_q == '0));

    assert_rewind_keeps_output_R10: assert property (@(posedge rclk) disable iff (ptr_clr)
        !rt_n |=> $stable(dout_q));

endmodule

// File: rtl/dualclk_fifo.sv
// Top of the dual-clock FIFO: storage, write and read controllers, and
// the two pointer synchronisers, plus output-enable gating of the data.
// Assumes: both reset inputs are held low for at least SYNC_STAGES+1
// edges of each clock, and rewind is used while the write side is idle.
module dualclk_fifo
    import dualclk_fifo_pkg::*;
#(
    parameter int unsigned AW = 4,
    parameter int unsigned DW = 18
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          mrst_n,
    input  logic          prst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] din,
    input  logic          rd_en,
    input  logic          rt_n,
    input  logic          oe,
    input  logic [AW-1:0] ae_level,
    input  logic [AW-1:0] af_level,
    output logic [DW-1:0] q,
    output logic          empty,
    output logic          almost_empty,
    output logic          full,
    output logic          half_full,
    output logic          almost_full
);

    localparam int unsigned PW = AW + 1;

    logic [PW-1:0] wptr, wgray, rptr, rgray;
    logic [PW-1:0] wptr_in_r, rptr_in_w;
    logic [DW-1:0] mem_rdata, dout;
    logic          we;
    logic          clr_n;

    assign clr_n = mrst_n && prst_n;

    fifo_dp_ram #(.AW(AW), .DW(DW)) u_ram (
        .wclk  (wclk),
        .we    (we),
        .waddr (wptr[AW-1:0]),
        .wdata (din),
        .raddr (rptr[AW-1:0]),
        .rdata (mem_rdata)
    );

    fifo_wr_ctrl #(.AW(AW)) u_wr (
        .wclk        (wclk),
        .mrst_n      (mrst_n),
        .prst_n      (prst_n),
        .wr_en       (wr_en),
        .af_level    (af_level),
        .rptr_sync   (rptr_in_w),
        .wptr        (wptr),
        .wgray       (wgray),
        .we          (we),
        .full        (full),
        .half_full   (half_full),
        .almost_full (almost_full)
    );

    fifo_rd_ctrl #(.AW(AW), .DW(DW)) u_rd (
        .rclk         (rclk),
        .mrst_n       (mrst_n),
        .prst_n       (prst_n),
        .rd_en        (rd_en),
        .rt_n         (rt_n),
        .ae_level     (ae_level),
        .wptr_sync    (wptr_in_r),
        .mem_rdata    (mem_rdata),
        .rptr         (rptr),
        .rgray        (rgray),
        .dout         (dout),
        .empty        (empty),
        .almost_empty (almost_empty)
    );

    fifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_w2r (
        .clk     (rclk),
        .clr_n   (clr_n),
        .gray_in (wgray),
        .bin_out (wptr_in_r)
    );

    fifo_gray_sync #(.W(PW), .STAGES(SYNC_STAGES)) u_r2w (
        .clk     (wclk),
        .clr_n   (clr_n),
        .gray_in (rgray),
        .bin_out (rptr_in_w)
    );

    assign q = oe ? dout : '0;

    assert_oe_gates_output_R11: assert property (@(posedge rclk) disable iff (!clr_n)
        !oe |-> (q == '0));

endmodule

// File: tb/dualclk_fifo_test.sv
`timescale 1ns/100ps
module dualclk_fifo_test;

    localparam int AW = 4;
    localparam int DW = 18;
    localparam int DEPTH = 1 << AW;

    logic wclk = 1'b0, rclk = 1'b0;
    logic mrst_n = 1'b0, prst_n = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, rt_n = 1'b1, oe = 1'b1;
    logic [DW-1:0] din = '0;
    logic [AW-1:0] ae_level = 4'd2, af_level = 4'd3;
    logic [DW-1:0] q;
    logic empty, almost_empty, full, half_full, almost_full;

    int n_chk = 0, n_fail = 0;
    int ae_l = 2, af_l = 3;
    bit done = 0;

    always #2   wclk = ~wclk;   // 250 MHz write clock
    always #3.5 rclk = ~rclk;   // unrelated read clock

    dualclk_fifo #(.AW(AW), .DW(DW)) uut (
        .wclk(wclk), .rclk(rclk), .mrst_n(mrst_n), .prst_n(prst_n),
        .wr_en(wr_en), .din(din), .rd_en(rd_en), .rt_n(rt_n), .oe(oe),
        .ae_level(ae_level), .af_level(af_level), .q(q),
        .empty(empty), .almost_empty(almost_empty), .full(full),
        .half_full(half_full), .almost_full(almost_full)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge rclk);
        repeat (4) @(negedge wclk);
    endtask

    task automatic wr_word(input logic [DW-1:0] v);
        @(negedge wclk); wr_en = 1'b1; din = v;
        @(negedge wclk); wr_en = 1'b0;
    endtask

    task automatic rd_word();
        @(negedge rclk); rd_en = 1'b1;
        @(negedge rclk); rd_en = 1'b0;
    endtask

    task automatic check_flags(input int n);
        chk("R3 empty", 32'(empty), 32'(n == 0));
        chk("R4 full", 32'(full), 32'(n == DEPTH));
        chk("R5 half_full", 32'(half_full), 32'(n > DEPTH / 2));
        chk("R6 almost_empty", 32'(almost_empty), 32'(n <= ae_l));
        chk("R7 almost_full", 32'(almost_full), 32'(n >= DEPTH - af_l));
    endtask

    task automatic do_reset(input bit master);
        @(negedge wclk);
        if (master) mrst_n = 1'b0; else prst_n = 1'b0;
        repeat (4) @(negedge wclk);
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        mrst_n = 1'b1; prst_n = 1'b1;
        settle();
    endtask

    task automatic finish_test();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #400000;
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        finish_test();
    end

    initial begin
        // R8: master reset captures thresholds 2 and 3
        do_reset(1'b1);
        chk("R8 q after master reset", 32'(q), 0);
        check_flags(0);

        // R1: written word stays off q until read
        wr_word(18'h100);
        settle();
        chk("R1 no output before read", 32'(q), 0);
        check_flags(1);

        // Fill sweep: every occupancy up to DEPTH
        for (int i = 1; i < DEPTH; i++) begin
            wr_word(18'(18'h100 + i));
            settle();
            check_flags(i + 1);
        end

        // R4: write while full is dropped
        wr_word(18'h3FFFF);
        settle();
        check_flags(DEPTH);

        // Drain sweep with data order check (R2)
        for (int i = 0; i < DEPTH; i++) begin
            rd_word();
            settle();
            chk("R2 order", 32'(q), 32'(18'h100 + i));
            check_flags(DEPTH - 1 - i);
        end

        // R3: read while empty leaves q alone
        rd_word();
        settle();
        chk("R3 empty read ignored", 32'(q), 32'h10F);
        check_flags(0);

        // R11: output enable gating
        @(negedge rclk); oe = 1'b0; #1;
        chk("R11 q zero when oe low", 32'(q), 0);
        oe = 1'b1; #1;
        chk("R11 q restored", 32'(q), 32'h10F);

        // R2: streaming across pointer wrap
        for (int k = 0; k < 3; k++) begin
            for (int j = 0; j < 10; j++) wr_word(18'(18'h2000 + k * 16 + j));
            settle();
            check_flags(10);
            for (int j = 0; j < 10; j++) begin
                rd_word();
                settle();
                chk("R2 wrap data", 32'(q), 32'(18'h2000 + k * 16 + j));
            end
        end

        // R9: partial reset flushes but keeps thresholds 2 and 3
        for (int j = 0; j < 3; j++) wr_word(18'(18'h700 + j));
        ae_level = 4'd0; af_level = 4'd0;
        do_reset(1'b0);
        chk("R9 empty after partial reset", 32'(empty), 1);
        chk("R9 q cleared by partial reset", 32'(q), 0);
        for (int n = 1; n <= 13; n++) begin
            wr_word(18'(18'h800 + n));
            settle();
            check_flags(n);
        end

        // R10: rewind with a simultaneous read
        do_reset(1'b0);
        for (int j = 0; j < 5; j++) wr_word(18'(18'h500 + j));
        settle();
        for (int j = 0; j < 3; j++) begin
            rd_word();
            settle();
            chk("R10 pre-rewind data", 32'(q), 32'(18'h500 + j));
        end
        @(negedge rclk); rt_n = 1'b0; rd_en = 1'b1;
        @(negedge rclk); rt_n = 1'b1; rd_en = 1'b0;
        settle();
        chk("R10 rewind leaves q", 32'(q), 32'h502);
        check_flags(5);
        for (int j = 0; j < 5; j++) begin
            rd_word();
            settle();
            chk("R10 reread data", 32'(q), 32'(18'h500 + j));
        end
        chk("R10 empty after reread", 32'(empty), 1);

        // R8: master reset recaptures thresholds 0 and 0
        do_reset(1'b1);
        ae_l = 0; af_l = 0;
        check_flags(0);
        wr_word(18'h1);
        settle();
        check_flags(1);
        for (int n = 2; n <= DEPTH; n++) wr_word(18'(n));
        settle();
        check_flags(DEPTH);

        finish_test();
    end

endmodule